// File: doc/BRIEF.md
# Logarithmic Multiplexer Shifter

A purely combinational word shifter for an integer datapath. It takes a data word, an unsigned shift distance and a two-bit mode, and returns the shifted word in the same cycle. The distance comes from one input, whether the instruction held it as a constant or read it from a register. The logic is a cascade of 2-to-1 multiplexer levels, one per bit of the distance. The level for distance bit k moves the word right by 2^k places or passes it through unchanged.

Every mode runs through the same right-moving cascade. A left shift mirrors the word bit by bit before the cascade and mirrors the result again after it. Each mode sets what enters at the top of each level: zeros, copies of the operand's sign bit, or the bits that the level pushes out at the bottom, which gives a rotation.

With the default 32-bit width the distance is 5 bits, from 0 to 31, and there are exactly five multiplexer levels between input and output.

Top module: `barrel_shifter`

## Requirements
- R1: With mode 2'b00 (logical left) the result equals the data moved toward bit 31 by the distance, and the vacated low bits are zero.
- R2: With mode 2'b01 (logical right) the result equals the data moved toward bit 0 by the distance, and the vacated high bits are zero.
- R3: A distance of 0 returns the data unchanged in every mode.
- R4: With mode 2'b10 (arithmetic right) the data moves toward bit 0, and every vacated high bit equals bit 31 of the input data.
- R5: With mode 2'b11 (rotate right) the bits that leave bit 0 re-enter at bit 31, so result bit i equals data bit (i + distance) mod 32 and the number of one bits is preserved.
- R6: The largest distance, 31, is handled in every mode. For example, logical left of 1 gives 32'h8000_0000, and rotate right of 1 gives 32'h0000_0002.
- R7: The result is a combinational function of the current inputs and holds no state, so it follows any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Operand to be shifted |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| mode_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| result_o | output | 32 | Shifted word |

## Verification
Random words and distances are applied in every mode. Operands with bit 31 set are then set against operands with bit 31 clear, which separates an arithmetic right shift from a logical one. Single set bits moved by 31 places test the full reach of the widest level and the mirroring used for left shifts. Rotations by 16 and by 31 test the wrap paths, and a distance of 0 in each mode shows that no level changes the word when it should pass it through.

// File: rtl/barrel_shifter_pkg.sv
package barrel_shifter_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/bs_mirror.sv
module bs_mirror #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dout[i] = din[WIDTH-1-i];
  end
endmodule

// File: rtl/bs_stage.sv
// One level of the cascade: moves the word right by DIST places when en is set.
module bs_stage #(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             rotate,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  logic [DIST-1:0] top_bits;

  // Bits that enter at the top: wrapped-out bits or the fill value.
  assign top_bits = rotate ? din[DIST-1:0] : {DIST{fill}};
  assign dout     = en ? {top_bits, din[WIDTH-1:DIST]} : din;
endmodule

// File: rtl/bs_cascade.sv
module bs_cascade #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             rotate,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] lvl [0:AMT_W];

  assign lvl[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
    bs_stage #(
      .WIDTH(WIDTH),
      .DIST (1 << k)
    ) stage_i (
      .din   (lvl[k]),
      .en    (amt[k]),
      .rotate(rotate),
      .fill  (fill),
      .dout  (lvl[k+1])
    );
  end

  assign dout = lvl[AMT_W];
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] result_o
);
  shift_mode_e      mode;
  logic             go_left;
  logic             rot_en;
  logic             fill_bit;
  logic [WIDTH-1:0] data_rev;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] core_rev;

  assign mode     = shift_mode_e'(mode_i);
  assign go_left  = (mode == SH_LSL);
  assign rot_en   = (mode == SH_ROR);
  assign fill_bit = (mode == SH_ASR) && data_i[WIDTH-1];

  bs_mirror #(.WIDTH(WIDTH)) pre_i (
    .din (data_i),
    .dout(data_rev)
  );

  assign core_in = go_left ? data_rev : data_i;

  bs_cascade #(.WIDTH(WIDTH)) core_i (
    .din   (core_in),
    .amt   (amt_i),
    .rotate(rot_en),
    .fill  (fill_bit),
    .dout  (core_out)
  );

  bs_mirror #(.WIDTH(WIDTH)) post_i (
    .din (core_out),
    .dout(core_rev)
  );

  assign result_o = go_left ? core_rev : core_out;
endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] lsb_one;
  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] high_mask;

  always_comb begin
    lsb_one   = WIDTH'(1);
    low_mask  = (lsb_one << amt_i) - lsb_one;
    high_mask = ~({WIDTH{1'b1}} >> amt_i);

    // R3: zero distance is a pass-through
    a_r3_zero_pass: assert (amt_i != '0 || result_o == data_i)
      else $error("R3: zero distance changed the data");
    // R1: vacated low bits of a left shift are zero
    a_r1_left_zero_fill: assert (mode_i != 2'b00 || (result_o & low_mask) == '0)
      else $error("R1: left shift low bits not zero");
    // R2: vacated high bits of a logical right shift are zero
    a_r2_right_zero_fill: assert (mode_i != 2'b01 || (result_o & high_mask) == '0)
      else $error("R2: logical right high bits not zero");
    // R4: vacated high bits of an arithmetic right shift copy the sign
    a_r4_sign_fill: assert (mode_i != 2'b10 ||
                            (result_o & high_mask) == (data_i[WIDTH-1] ? high_mask : '0))
      else $error("R4: arithmetic right fill differs from sign");
    // R5: rotation keeps the count of ones
    a_r5_rot_ones: assert (mode_i != 2'b11 || $countones(result_o) == $countones(data_i))
      else $error("R5: rotate lost or gained bits");
  end
endmodule

bind barrel_shifter barrel_shifter_chk #(.WIDTH(WIDTH)) chk_i (
  .data_i  (data_i),
  .amt_i   (amt_i),
  .mode_i  (mode_i),
  .result_o(result_o)
);

// File: tb/barrel_shifter_tb_top.sv
`timescale 1ns/1ps
module barrel_shifter_tb_top;
  logic        clk;
  logic [31:0] data;
  logic [4:0]  amt;
  logic [1:0]  mode;
  logic [31:0] result;
  int          n_cmp;
  int          n_bad;
  int          cyc;
  bit          done;

  barrel_shifter dut_i (
    .data_i  (data),
    .amt_i   (amt),
    .mode_i  (mode),
    .result_o(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [31:0] model(input logic [31:0] d, input logic [4:0] a,
                                        input logic [1:0] m);
    logic [31:0] r;
    case (m)
      2'b00:   r = d << a;
      2'b01:   r = d >> a;
      2'b10:   r = 32'($signed(d) >>> a);
      default: begin
        for (int i = 0; i < 32; i++) r[i] = d[(i + int'(a)) % 32];
      end
    endcase
    return r;
  endfunction

  task automatic apply(input logic [31:0] d, input logic [4:0] a, input logic [1:0] m,
                       input string tag, input logic [31:0] exp);
    @(negedge clk);
    data = d; amt = a; mode = m;
    #1;
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: d=%h amt=%0d mode=%0d got %h expected %h", tag, d, a, m, result, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; done = 1'b0;
    data = '0; amt = '0; mode = '0;
    void'($urandom(32'd20240611));

    // Idle state: zero in gives zero out
    apply(32'h0, 5'd0, 2'b00, "R7 idle", 32'h0);
    // R3: zero distance in each mode
    for (int m = 0; m < 4; m++)
      apply(32'hA5C3_0F81, 5'd0, 2'(m), "R3 zero distance", 32'hA5C3_0F81);
    // R1 / R6 left extremes
    apply(32'h1, 5'd31, 2'b00, "R6 R1 left by 31", 32'h8000_0000);
    apply(32'hFFFF_FFFF, 5'd4, 2'b00, "R1 left zero fill", 32'hFFFF_FFF0);
    // R2 / R6 logical right
    apply(32'h8000_0000, 5'd31, 2'b01, "R6 R2 right by 31", 32'h1);
    apply(32'hF000_0000, 5'd8, 2'b01, "R2 zero fill", 32'h00F0_0000);
    // R4 arithmetic right, negative and positive
    apply(32'h8000_0000, 5'd4, 2'b10, "R4 negative sign fill", 32'hF800_0000);
    apply(32'h4000_0000, 5'd30, 2'b10, "R4 positive", 32'h1);
    apply(32'h8000_0000, 5'd31, 2'b10, "R6 R4 by 31", 32'hFFFF_FFFF);
    // R5 rotate
    apply(32'h1, 5'd1, 2'b11, "R5 wrap one", 32'h8000_0000);
    apply(32'h1234_5678, 5'd16, 2'b11, "R5 half swap", 32'h5678_1234);
    apply(32'h1, 5'd31, 2'b11, "R6 R5 by 31", 32'h2);
    // R7: result follows input change without clock edge
    data = 32'h0000_0100; amt = 5'd4; mode = 2'b01;
    #1; n_cmp++;
    if (result !== 32'h10) begin
      n_bad++; $display("FAIL R7: got %h expected %h", result, 32'h10);
    end
    // Random vectors across all modes
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [4:0]  a;
      logic [1:0]  m;
      d = $urandom; a = 5'($urandom); m = 2'($urandom);
      if (i % 4 == 0) d[31] = 1'b1;
      apply(d, a, m, "R1 R2 R4 R5 random", model(d, a, m));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule